// File: doc/BRIEF.md
# Interrupt Status and Mask Register Front End

This block is the register-side interrupt logic of a serial flash controller. A transfer engine raises a one-cycle word-complete pulse; the block latches it into a raw status bit. It also holds an enable mask for that bit and drives an interrupt line from the status bit ANDed with the mask.

Software never writes status or mask as plain read-write registers. The raw status and the mask are each changed through their own set and clear addresses. Writing a one sets or clears the bit, and writing a zero leaves it as it was. A second status view returns only pending sources that are also enabled. Writing ones to that view acknowledges them. The register port is a simple single-cycle write strobe with a combinational read data path.

Top module: `irq_setclr_regs`

## Requirements
- R1: After reset the raw status, the enable mask and `irq` are all zero, so every mapped address reads zero.
- R2: A `wc_pulse` at a clock edge sets the word-complete status. Word-complete is bit 1 at every mapped address, and the raw view at offset 0x20 shows it from the next cycle on.
- R3: Writing a one in bit 1 at offset 0x28 sets the mask bit. Offsets 0x28 and 0x2C both read back the mask in bit 1.
- R4: Writing a one in bit 1 at offset 0x2C clears the mask bit.
- R5: Offset 0x24 reads raw status ANDed with the mask in bit 1, so it reads zero whenever no enabled source is pending.
- R6: Writing a one in bit 1 at offset 0x24 clears the raw status.
- R7: Writing a one in bit 1 at offset 0x20 sets the raw status, so software can test the interrupt path.
- R8: A write with bit 1 at zero changes neither status nor mask, whichever of the four addresses it targets.
- R9: `irq` is registered. It goes to the OR of the enabled status bits one clock after that state is reached.
- R10: When `wc_pulse` and a status-clearing write fall in the same cycle, the status ends up set.
- R11: Unimplemented bits read zero, and addresses outside the four mapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wc_pulse | input | 1 | Word-complete pulse from the transfer engine |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (8) | Register byte offset for read and write |
| reg_wdata | input | DW (32) | Register write data |
| reg_rdata | output | DW (32) | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Registered interrupt request |

## Verification
Every starting combination of status and mask is combined with a write to each of the four addresses, with bit 1 both one and zero, and with the word-complete pulse both present and absent. The all-ones-except-bit-1 data pattern separates a correct bit-1 decode from a decode that reacts to any nonzero word. The pulse-plus-clear cases separate set priority from clear priority. Checking `irq` in the cycle after the write and again one cycle later separates a registered line from a combinational one.

// File: rtl/irq_setclr_regs.sv
module irq_setclr_regs #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] BASE = 8'h20,
  parameter int WC_BIT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wc_pulse,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  localparam logic [AW-1:0] A_RAW = BASE;
  localparam logic [AW-1:0] A_ACK = BASE + AW'(4);
  localparam logic [AW-1:0] A_ESET = BASE + AW'(8);
  localparam logic [AW-1:0] A_ECLR = BASE + AW'(12);

  logic stat_q, en_q;
  logic wbit;

  assign wbit = reg_wdata[WC_BIT];

  wire set_stat = reg_we && (reg_addr == A_RAW) && wbit;
  wire clr_stat = reg_we && (reg_addr == A_ACK) && wbit;
  wire set_en   = reg_we && (reg_addr == A_ESET) && wbit;
  wire clr_en   = reg_we && (reg_addr == A_ECLR) && wbit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      en_q   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      stat_q <= (stat_q && !clr_stat) || set_stat || wc_pulse;
      en_q   <= (en_q || set_en) && !clr_en;
      irq    <= stat_q && en_q;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_RAW:          reg_rdata[WC_BIT] = stat_q;
      A_ACK:          reg_rdata[WC_BIT] = stat_q && en_q;
      A_ESET, A_ECLR: reg_rdata[WC_BIT] = en_q;
      default:        reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_setclr_regs_chk.sv
module irq_setclr_regs_chk #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] BASE = 8'h20,
  parameter int WC_BIT = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wc_pulse,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          stat_q,
  input logic          en_q,
  input logic          irq
);
  // R2 and R10: a pulse always leaves status set, even against a clear
  a_r10_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wc_pulse |=> stat_q);

  // R6
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == BASE + AW'(4) && reg_wdata[WC_BIT] && !wc_pulse) |=> !stat_q);

  // R4
  a_r4_mask_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == BASE + AW'(12) && reg_wdata[WC_BIT]) |=> !en_q);

  // R8
  a_r8_zero_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we || !reg_wdata[WC_BIT]) |=> $stable(en_q));

  // R9
  a_r9_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(stat_q && en_q));

  // R9
  a_r9_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !irq) |=> !irq);
endmodule

bind irq_setclr_regs irq_setclr_regs_chk #(.AW(AW), .DW(DW), .BASE(BASE), .WC_BIT(WC_BIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .wc_pulse(wc_pulse), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .stat_q(stat_q),
  .en_q(en_q), .irq(irq)
);

// File: tb/irq_setclr_regs_tb_top.sv
`timescale 1ns/100ps
module irq_setclr_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wc_pulse = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_setclr_regs dut_i (
    .clk(clk), .rst_n(rst_n), .wc_pulse(wc_pulse), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input string tag, input logic [31:0] exp);
    reg_addr = a;
    #0.5;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_we = 1'b0; wc_pulse = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #150000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] addrs [4];
    addrs[0] = 8'h20; addrs[1] = 8'h24; addrs[2] = 8'h28; addrs[3] = 8'h2C;
    do_reset();
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    for (int i = 0; i < 4; i++) rd(addrs[i], "R1 reset read", 32'd0);
    rd(8'h30, "R11 unmapped read", 32'd0);

    for (int s0 = 0; s0 < 2; s0++)
      for (int e0 = 0; e0 < 2; e0++)
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 2; b++)
            for (int p = 0; p < 2; p++) begin
              logic s1, e1;
              string t;
              do_reset();
              if (s0 == 1) wr(8'h20, 32'h2);
              if (e0 == 1) wr(8'h28, 32'h2);
              @(negedge clk);
              reg_we = 1'b1; reg_addr = addrs[a];
              reg_wdata = (b == 1) ? 32'h0000_0002 : 32'hFFFF_FFFD;
              wc_pulse = (p == 1);
              @(negedge clk);
              reg_we = 1'b0; reg_wdata = '0; wc_pulse = 1'b0;
              s1 = ((s0 == 1) && !(a == 1 && b == 1)) || (a == 0 && b == 1) || (p == 1);
              e1 = ((e0 == 1) || (a == 2 && b == 1)) && !(a == 3 && b == 1);
              if (p == 1 && a == 1 && b == 1) t = "R10";
              else if (b == 0) t = "R8";
              else if (a == 0) t = "R7";
              else if (a == 1) t = "R6";
              else if (a == 2) t = "R3";
              else t = "R4";
              t = $sformatf("%s s%0d e%0d a%0d b%0d p%0d", t, s0, e0, a, b, p);
              chk({"R9 irq lag ", t}, {31'd0, irq}, {31'd0, (s0 == 1) && (e0 == 1)});
              rd(8'h20, {"R2 raw ", t}, {30'd0, s1, 1'b0});
              rd(8'h24, {"R5 enabled view ", t}, {30'd0, s1 && e1, 1'b0});
              rd(8'h28, {"R3 mask ", t}, {30'd0, e1, 1'b0});
              rd(8'h2C, {"R4 mask ", t}, {30'd0, e1, 1'b0});
              rd(8'h40, {"R11 unmapped ", t}, 32'd0);
              @(negedge clk);
              chk({"R9 irq follows ", t}, {31'd0, irq}, {31'd0, s1 && e1});
            end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule